// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block decides, in the same cycle, whether the instruction sitting in the decode stage of a five-stage in-order integer pipeline may issue to execute. It looks at the source registers of the decode instruction and at the destinations of the instructions now in execute and in memory. It also uses the load flags of those two producers, the class of the decode instruction, and three configuration bits that say which bypass paths the datapath has. From these it drives three controls: a hold for the decode register, an enable for the program counter, and a bubble request that turns the issued slot into a no-operation.

The register file writes early in a cycle and reads late, so a producer in writeback never conflicts with decode and is not an input. The decision is purely combinational and ends in one of three verdicts. RUN lets the instruction issue. DATA_STALL freezes both fetch and decode and issues a bubble. CTRL_STALL issues a bubble and keeps decode frozen, but lets the program counter take the target computed in decode, so the wrongly fetched instruction never reaches decode. The verdict is re-derived every cycle, and any verdict may follow any other. RUN moves to DATA_STALL on an unresolved operand and to CTRL_STALL on a redirect, and each stall returns to RUN once its cause clears.

Each source register is given a role by the instruction class. The role can be ALU operand, store data, zero test or jump register. The forwarding settings then pick the stall rule for that role.

Top module: `hz_interlock_ctrl`

## Requirements
- R1: Class codes on `dec_class` are 0 ALU (both sources are ALU operands), 1 load (source 0 is the address base), 2 store (source 0 is the base, source 1 is the store data), 3 zero-test branch (source 0 is tested), 4 register jump (source 0 is the target), 5 direct jump (no sources) and 6 no-op. With no hazard the outputs are hold 0, PC enable 1 and bubble 0.
- R2: A data or load hazard gives hold 1, PC enable 0 and bubble 1.
- R3: A class 3, 4 or 5 instruction whose `dec_target` differs from `pc_now` raises a control stall when it has no data hazard: hold 1, PC enable 1 and bubble 1.
- R4: Register 0 never creates a dependency, whether it is the source or the destination. A producer whose write flag is low never creates one either.
- R5: With ALU forwarding off, an ALU-operand source stalls when it matches the destination of the execute producer or the memory producer.
- R6: With ALU forwarding on, an ALU-operand source stalls only when it matches a load in execute. A match with a non-load in execute, or with any producer in memory, does not stall.
- R7: A register-jump source stalls on a match with the execute or memory producer, whatever the forwarding settings are.
- R8: With zero forwarding off, a zero-test source stalls on a match in execute or memory. With it on, the source stalls only when the matching producer is a load, in either stage.
- R9: A store-data source stalls on a match in execute or memory when store forwarding is off. When it is on, the source stalls only on a load in execute.
- R10: A data hazard takes priority over a control stall, so the PC enable stays 0.
- R11: A source whose valid bit is low is ignored. A no-op never stalls, whatever its sources or target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| dec_class | input | 3 | Class of the decode instruction |
| dec_src | input | 2 x REG_W | Source register numbers of the decode instruction, entries 0 and 1 |
| dec_src_vld | input | 2 | Valid bit for each source |
| ex_dst | input | REG_W | Destination register of the execute producer |
| ex_wr | input | 1 | Execute producer writes a register |
| ex_load | input | 1 | Execute producer is a load |
| mem_dst | input | REG_W | Destination register of the memory producer |
| mem_wr | input | 1 | Memory producer writes a register |
| mem_load | input | 1 | Memory producer is a load |
| cfg_alu_fwd | input | 1 | ALU result bypass exists |
| cfg_zero_fwd | input | 1 | Bypass into the zero comparator exists |
| cfg_store_fwd | input | 1 | Bypass into the store data exists |
| dec_target | input | ADDR_W | Next address computed in decode |
| pc_now | input | ADDR_W | Address currently held in the PC |
| dec_hold | output | 1 | Keep the decode register and its PC copy |
| pc_en | output | 1 | Let the PC load its next value |
| bubble | output | 1 | Issue a no-operation into execute |

## Verification
The bench goes after the load-use case with forwarding on. A design that treated a memory-stage load as unresolved would insert a second bubble. A design that forwarded a load from execute would let a stale operand issue. It checks that a register jump still stalls with every bypass enabled. It also checks that a redirect arriving together with a data hazard keeps the PC frozen, since a design that let the control stall win would skip the instruction being waited on. Register 0, producers that do not write, sources with a low valid bit and no-ops with a mismatched target are all driven against live matches. A design that compared register numbers without these qualifiers would show spurious stalls.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int NUM_SRC = 2;

    typedef enum logic [2:0] {
        CL_ALU   = 3'd0,
        CL_LOAD  = 3'd1,
        CL_STORE = 3'd2,
        CL_BRZ   = 3'd3,
        CL_JREG  = 3'd4,
        CL_JUMP  = 3'd5,
        CL_NOP   = 3'd6
    } iclass_e;

    typedef enum logic [2:0] {
        RL_NONE,
        RL_ALU,
        RL_STDATA,
        RL_ZERO,
        RL_JREG
    } role_e;

    typedef enum logic [1:0] {
        V_RUN,
        V_DATA_STALL,
        V_CTRL_STALL
    } verdict_e;

    typedef struct packed {
        logic ex;
        logic mem;
        logic ex_ld;
        logic mem_ld;
    } hit_t;

    // Role a given source slot plays for an instruction class
    function automatic role_e src_role(iclass_e c, int idx);
        role_e r;
        r = RL_NONE;
        unique case (c)
            CL_ALU:   r = RL_ALU;
            CL_LOAD:  r = (idx == 0) ? RL_ALU : RL_NONE;
            CL_STORE: r = (idx == 0) ? RL_ALU : RL_STDATA;
            CL_BRZ:   r = (idx == 0) ? RL_ZERO : RL_NONE;
            CL_JREG:  r = (idx == 0) ? RL_JREG : RL_NONE;
            default:  r = RL_NONE;
        endcase
        return r;
    endfunction

    function automatic logic is_flow(iclass_e c);
        return (c == CL_BRZ) || (c == CL_JREG) || (c == CL_JUMP);
    endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             src_vld,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic             mem_load,
    output hit_t             hit
);

    logic live;

    always_comb begin
        live       = src_vld && (src != '0);
        hit.ex     = live && ex_wr  && (ex_dst  == src);
        hit.mem    = live && mem_wr && (mem_dst == src);
        hit.ex_ld  = hit.ex  && ex_load;
        hit.mem_ld = hit.mem && mem_load;
    end

endmodule

// File: rtl/hz_role_policy.sv
module hz_role_policy
    import hz_pkg::*;
(
    input  role_e role,
    input  logic  cfg_alu_fwd,
    input  logic  cfg_zero_fwd,
    input  logic  cfg_store_fwd,
    input  hit_t  hit,
    output logic  stall
);

    always_comb begin
        unique case (role)
            RL_NONE:   stall = 1'b0;
            RL_ALU:    stall = cfg_alu_fwd   ? hit.ex_ld : (hit.ex | hit.mem);
            RL_STDATA: stall = cfg_store_fwd ? hit.ex_ld : (hit.ex | hit.mem);
            RL_ZERO:   stall = cfg_zero_fwd  ? (hit.ex_ld | hit.mem_ld)
                                             : (hit.ex | hit.mem);
            RL_JREG:   stall = hit.ex | hit.mem;
            default:   stall = 1'b0;
        endcase
    end

endmodule

// File: rtl/hz_interlock_ctrl.sv
module hz_interlock_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int ADDR_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2:0]                      dec_class,
    input  logic [NUM_SRC-1:0][REG_W-1:0]   dec_src,
    input  logic [NUM_SRC-1:0]              dec_src_vld,
    input  logic [REG_W-1:0]                ex_dst,
    input  logic                            ex_wr,
    input  logic                            ex_load,
    input  logic [REG_W-1:0]                mem_dst,
    input  logic                            mem_wr,
    input  logic                            mem_load,
    input  logic                            cfg_alu_fwd,
    input  logic                            cfg_zero_fwd,
    input  logic                            cfg_store_fwd,
    input  logic [ADDR_W-1:0]               dec_target,
    input  logic [ADDR_W-1:0]               pc_now,
    output logic                            dec_hold,
    output logic                            pc_en,
    output logic                            bubble
);

    iclass_e              cls;
    logic [NUM_SRC-1:0]   src_stall;
    logic                 redirect;
    verdict_e             verdict;

    assign cls = iclass_e'(dec_class);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        hit_t  hit;
        role_e role;

        assign role = src_role(cls, i);

        hz_src_match #(.REG_W(REG_W)) u_match (
            .src      (dec_src[i]),
            .src_vld  (dec_src_vld[i]),
            .ex_dst   (ex_dst),
            .ex_wr    (ex_wr),
            .ex_load  (ex_load),
            .mem_dst  (mem_dst),
            .mem_wr   (mem_wr),
            .mem_load (mem_load),
            .hit      (hit)
        );

        hz_role_policy u_policy (
            .role          (role),
            .cfg_alu_fwd   (cfg_alu_fwd),
            .cfg_zero_fwd  (cfg_zero_fwd),
            .cfg_store_fwd (cfg_store_fwd),
            .hit           (hit),
            .stall         (src_stall[i])
        );
    end

    assign redirect = is_flow(cls) && (dec_target != pc_now);

    // Verdict selection: data hazards outrank redirects
    always_comb begin
        if (|src_stall)
            verdict = V_DATA_STALL;
        else if (redirect)
            verdict = V_CTRL_STALL;
        else
            verdict = V_RUN;
    end

    // Output decode per verdict
    always_comb begin
        unique case (verdict)
            V_RUN: begin
                dec_hold = 1'b0;
                pc_en    = 1'b1;
                bubble   = 1'b0;
            end
            V_DATA_STALL: begin
                dec_hold = 1'b1;
                pc_en    = 1'b0;
                bubble   = 1'b1;
            end
            V_CTRL_STALL: begin
                dec_hold = 1'b1;
                pc_en    = 1'b1;
                bubble   = 1'b1;
            end
            default: begin
                dec_hold = 1'b0;
                pc_en    = 1'b1;
                bubble   = 1'b0;
            end
        endcase
    end

    // R11: a no-op issues freely
    a_r11_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_class == 3'd6) |-> (!dec_hold && pc_en && !bubble));

    // R2: a frozen PC always comes with a held decode and a bubble
    a_r2_freeze_is_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_en) |-> (dec_hold && bubble));

    // R3: a stall that still advances the PC needs a flow change that mismatches
    a_r3_ctrl_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en && dec_hold) |->
        ((dec_class == 3'd3 || dec_class == 3'd4 || dec_class == 3'd5)
         && (dec_target != pc_now)));

    // R4: with no writing producer the PC is never frozen
    a_r4_no_writer: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_wr && !mem_wr) |-> pc_en);

    // R6: with ALU forwarding and no execute writer, ALU ops never freeze
    a_r6_fwd_mem_free: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_alu_fwd && dec_class == 3'd0 && !ex_wr) |-> pc_en);

    // R7: register jump with a live producer always freezes
    a_r7_jreg_always: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_class == 3'd4 && dec_src_vld[0] && dec_src[0] != '0 &&
         ((ex_wr && ex_dst == dec_src[0]) || (mem_wr && mem_dst == dec_src[0])))
        |-> (!pc_en && dec_hold));

endmodule

// File: tb/hz_interlock_ctrl_bench.sv
`timescale 1ns/1ps
module hz_interlock_ctrl_bench;

    localparam int RW = 5;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      cls;
    logic [1:0][RW-1:0] src;
    logic [1:0]      vld;
    logic [RW-1:0]   ex_dst, mem_dst;
    logic            ex_wr, ex_ld, mem_wr, mem_ld;
    logic            f_alu, f_zero, f_st;
    logic [AW-1:0]   tgt, pc;
    logic            dec_hold, pc_en, bubble;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hz_interlock_ctrl #(.REG_W(RW), .ADDR_W(AW)) u_hz_interlock_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_class(cls), .dec_src(src),
        .dec_src_vld(vld), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_ld),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_ld),
        .cfg_alu_fwd(f_alu), .cfg_zero_fwd(f_zero), .cfg_store_fwd(f_st),
        .dec_target(tgt), .pc_now(pc),
        .dec_hold(dec_hold), .pc_en(pc_en), .bubble(bubble)
    );

    // {hold, pc_en, bubble}
    localparam logic [2:0] RUN  = 3'b010;
    localparam logic [2:0] DSTL = 3'b101;
    localparam logic [2:0] CSTL = 3'b111;

    // Reference rule per source slot (R1, R4-R9, R11)
    function automatic logic ref_src(int idx);
        logic live, hx, hm, lx, lm;
        int role; // 0 none, 1 alu operand, 2 store data, 3 zero test, 4 jump reg
        live = vld[idx] && (src[idx] != 0);
        hx = live && ex_wr && (ex_dst == src[idx]);
        hm = live && mem_wr && (mem_dst == src[idx]);
        lx = hx && ex_ld;
        lm = hm && mem_ld;
        case (cls)
            3'd0: role = 1;
            3'd1: role = (idx == 0) ? 1 : 0;
            3'd2: role = (idx == 0) ? 1 : 2;
            3'd3: role = (idx == 0) ? 3 : 0;
            3'd4: role = (idx == 0) ? 4 : 0;
            default: role = 0;
        endcase
        case (role)
            1: return f_alu ? lx : (hx || hm);
            2: return f_st ? lx : (hx || hm);
            3: return f_zero ? (lx || lm) : (hx || hm);
            4: return hx || hm;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] ref_out();
        if (ref_src(0) || ref_src(1)) return DSTL;          // R2, R10
        if ((cls == 3'd3 || cls == 3'd4 || cls == 3'd5) && tgt != pc) return CSTL; // R3
        return RUN;
    endfunction

    task automatic check(string req, logic [2:0] exp);
        logic [2:0] act;
        act = {dec_hold, pc_en, bubble};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got hold/pc_en/bubble=%b expected %b", req, act, exp);
        end
    endtask

    task automatic start_case();
        @(negedge clk);
        cls = 3'd6; src = '0; vld = 2'b00;
        ex_dst = '0; ex_wr = 0; ex_ld = 0;
        mem_dst = '0; mem_wr = 0; mem_ld = 0;
        f_alu = 0; f_zero = 0; f_st = 0;
        tgt = 32'h100; pc = 32'h100;
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        start_case();
        repeat (3) @(posedge clk);
        settle();
        check("R1 reset state no-op", RUN);
        @(negedge clk); rst_n = 1'b1;

        // R5: no ALU forwarding, producer in execute
        start_case(); cls = 3'd0; src[0] = 5'd3; vld = 2'b01; ex_dst = 5'd3; ex_wr = 1;
        settle(); check("R5 nofwd ex match", DSTL);
        // R5: producer in memory, matched by source 1
        start_case(); cls = 3'd0; src[1] = 5'd7; vld = 2'b10; mem_dst = 5'd7; mem_wr = 1;
        settle(); check("R5 nofwd mem match", DSTL);
        // R6: forwarding on, non-load in execute
        start_case(); f_alu = 1; cls = 3'd0; src[0] = 5'd3; vld = 2'b01; ex_dst = 5'd3; ex_wr = 1;
        settle(); check("R6 fwd ex alu", RUN);
        // R6: load-use in execute
        start_case(); f_alu = 1; cls = 3'd1; src[0] = 5'd3; vld = 2'b01; ex_dst = 5'd3; ex_wr = 1; ex_ld = 1;
        settle(); check("R6 fwd load-use", DSTL);
        // R6: load already in memory
        start_case(); f_alu = 1; cls = 3'd0; src[0] = 5'd3; vld = 2'b01; mem_dst = 5'd3; mem_wr = 1; mem_ld = 1;
        settle(); check("R6 fwd load in mem", RUN);
        // R4: register 0
        start_case(); cls = 3'd0; src[0] = 5'd0; vld = 2'b01; ex_dst = 5'd0; ex_wr = 1; mem_wr = 1;
        settle(); check("R4 register zero", RUN);
        // R4: producer without destination
        start_case(); cls = 3'd0; src[0] = 5'd4; vld = 2'b01; ex_dst = 5'd4; mem_dst = 5'd4;
        settle(); check("R4 no write flag", RUN);
        // R7: register jump with all forwarding on
        start_case(); f_alu = 1; f_zero = 1; f_st = 1; cls = 3'd4; src[0] = 5'd9; vld = 2'b01; mem_dst = 5'd9; mem_wr = 1;
        settle(); check("R7 jreg all fwd", DSTL);
        // R8: zero forwarding on, non-load producer
        start_case(); f_zero = 1; cls = 3'd3; src[0] = 5'd2; vld = 2'b01; ex_dst = 5'd2; ex_wr = 1;
        settle(); check("R8 zero fwd alu", RUN);
        // R8: zero forwarding off
        start_case(); cls = 3'd3; src[0] = 5'd2; vld = 2'b01; ex_dst = 5'd2; ex_wr = 1;
        settle(); check("R8 zero nofwd", DSTL);
        // R8: zero forwarding on, load in memory
        start_case(); f_zero = 1; cls = 3'd3; src[0] = 5'd2; vld = 2'b01; mem_dst = 5'd2; mem_wr = 1; mem_ld = 1;
        settle(); check("R8 zero fwd load mem", DSTL);
        // R9: store data without store forwarding
        start_case(); f_alu = 1; cls = 3'd2; src[1] = 5'd6; vld = 2'b11; src[0] = 5'd1; ex_dst = 5'd6; ex_wr = 1;
        settle(); check("R9 store nofwd", DSTL);
        // R9: store forwarding on
        start_case(); f_alu = 1; f_st = 1; cls = 3'd2; src[1] = 5'd6; vld = 2'b11; src[0] = 5'd1; ex_dst = 5'd6; ex_wr = 1;
        settle(); check("R9 store fwd", RUN);
        // R3: direct jump redirect
        start_case(); cls = 3'd5; tgt = 32'h200;
        settle(); check("R3 jump redirect", CSTL);
        start_case(); cls = 3'd5;
        settle(); check("R3 jump predicted", RUN);
        // R10: data hazard beats redirect
        start_case(); cls = 3'd4; src[0] = 5'd5; vld = 2'b01; ex_dst = 5'd5; ex_wr = 1; tgt = 32'h300;
        settle(); check("R10 data over ctrl", DSTL);
        // R11: invalid source ignored
        start_case(); cls = 3'd0; src[0] = 5'd5; vld = 2'b00; ex_dst = 5'd5; ex_wr = 1;
        settle(); check("R11 invalid source", RUN);
        // R11: no-op with matches and mismatched target
        start_case(); cls = 3'd6; src[0] = 5'd5; vld = 2'b11; ex_dst = 5'd5; ex_wr = 1; tgt = 32'h44;
        settle(); check("R11 nop quiet", RUN);

        // Random mix against the reference model
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 3000; n++) begin
            start_case();
            cls     = 3'($urandom_range(0, 6));
            src[0]  = 5'($urandom_range(0, 3));
            src[1]  = 5'($urandom_range(0, 3));
            vld     = 2'($urandom_range(0, 3));
            ex_dst  = 5'($urandom_range(0, 3));
            mem_dst = 5'($urandom_range(0, 3));
            ex_wr   = 1'($urandom_range(0, 1));
            ex_ld   = 1'($urandom_range(0, 1));
            mem_wr  = 1'($urandom_range(0, 1));
            mem_ld  = 1'($urandom_range(0, 1));
            f_alu   = 1'($urandom_range(0, 1));
            f_zero  = 1'($urandom_range(0, 1));
            f_st    = 1'($urandom_range(0, 1));
            pc      = 32'h100;
            tgt     = ($urandom_range(0, 1) != 0) ? 32'h100 : 32'h104;
            settle();
            check("R2 R3 random model", ref_out());
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule